// File: doc/BRIEF.md
# Chainable Serial Register Port

This block is a serial peripheral slave that lets a host read and write a small bank of control registers and one sticky status register. The host drives an active-low select, a serial clock and a serial data input. The block answers on a serial data output that it drives only while it returns read data. A second output repeats the serial input, delayed by exactly one frame, so that several of these blocks can sit in one chain on a single select line. Each device in the chain acts on the last frame it received before the select line rose.

A static mode input chooses between two frame sizes. The narrow frame carries one data byte. The wide frame carries two data bytes, which go to two adjacent registers. Every frame starts with a command byte: a read/write bit followed by a register address. Status events from the surrounding logic set sticky bits in the status register. While any bit is set, the block requests a low level on the open-drain interrupt line, and a ring indication is one of these events. Reading the status register clears the bits that the read returned.

All serial inputs are synchronised to the system clock and their edges are detected there. The serial clock must therefore be several times slower than the system clock. The minimum serial clock period also grows with the length of the chain.

Top module: `spi_chain_regif`

## Requirements
- R1: After reset the data output enable is low, the pass-through output is 0, the interrupt pull-down request is low and every control register reads 0.
- R2: A frame is sent MSB first. It is a command byte {bit7 = 1 for read / 0 for write, bits 6:0 = address} followed by the data. In narrow mode (mode input 0) the frame is 16 bits with one data byte. A write takes effect only after the select line rises, never during the transaction.
- R3: In wide mode (mode input 1) a frame is 24 bits. The first data byte goes to the addressed register and the second to address+1. A wide read returns both bytes in the same order.
- R4: A transaction whose bit count is zero or not a whole multiple of the frame size changes no register.
- R5: When several frames are sent under one select window, only the final frame's write is committed. Reads are answered in every frame that carries a read command.
- R6: The pass-through output repeats the serial input exactly one frame length (16 or 24 bits) later. It emits 0 for the first frame of each transaction.
- R7: The data output enable is high only during the data bits of a read frame. Read data is MSB first, and the enable drops again once the frame ends or the select line rises.
- R8: Addresses 0 to 14 are read/write control registers, and address 15 is the status register (default parameters). A write to address 15 or to an address above 15 changes nothing. A read of an address above 15 returns 0.
- R9: A high level on a bit of the event input sets the matching sticky status bit. The interrupt pull-down request is high while any status bit is set.
- R10: A read of the status register clears only the bits that it returned, and only when that read is the final frame of the transaction. Events that arrive after the data was captured stay set.
- R11: A transaction of more than 16 frames is discarded. A transaction of exactly 16 frames is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sclk | input | 1 | Serial clock, input sampled on its rising edge |
| spi_mosi | input | 1 | Serial data from the host or the previous device |
| wide_mode | input | 1 | 0 = 16-bit frames, 1 = 24-bit frames; held while selected |
| event_in | input | 8 | Status event levels (bit 0 = ring indication) |
| spi_miso | output | 1 | Serial read data |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; pad released when low |
| spi_thru | output | 1 | Frame-delayed copy of the serial input for the next device |
| irq_pulldown | output | 1 | High requests the open-drain interrupt pad to pull low |
| ctrl_regs | output | 120 | Control registers 0 to 14, register n at bits 8n+7:8n |

## Verification
The bench sends frames with one bit missing or a few bits left over, and checks that no register changes. A design that committed on any select rise would corrupt the register there. Chains of three, sixteen and seventeen frames check that only the last frame is committed and that the frame-count limit holds, which catches a design that commits the first frame or lets the count wrap. Status reads are placed in a non-final frame, and an event is raised in the middle of a status read. A design that cleared on every read, or cleared the whole register, would then lose a pending interrupt. The pass-through stream is compared bit by bit against the input shifted by the frame length in both modes, which catches an off-by-one delay or a delay line that is not cleared between transactions.

// File: rtl/spi_chain_pkg.sv
// Shared constants for the chainable serial register port.
// Assumes: command byte = read flag + 7-bit address, data bytes of 8 bits.
package spi_chain_pkg;
    localparam int BYTE_W    = 8;
    localparam int CMD_W     = 8;
    localparam int ADDR_W    = CMD_W - 1;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int FRAME_MAX = CMD_W + WORD_W;
    localparam int POS_W     = $clog2(FRAME_MAX + 1);

    localparam logic [POS_W-1:0] POS_CMD    = POS_W'(CMD_W);
    localparam logic [POS_W-1:0] POS_NARROW = POS_W'(CMD_W + BYTE_W);
    localparam logic [POS_W-1:0] POS_WIDE   = POS_W'(FRAME_MAX);
endpackage

// File: rtl/spi_edge_sync.sv
// Synchronises N asynchronous inputs into clk and flags their edges.
// Assumes: inputs stay stable for several clk periods between changes.
module spi_edge_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : gen_bit
        logic [STAGES:0] chain;

        // Shift the input through the synchroniser plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
            else        chain <= {chain[STAGES-1:0], din[g]};
        end

        assign level[g] = chain[STAGES-1];
        assign rise[g]  = chain[STAGES-1] & ~chain[STAGES];
        assign fall[g]  = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/spi_frame_engine.sv
// Serial frame engine: shifts in frames, tracks frame position and count,
// drives read data, keeps the pass-through delay line, and raises a commit
// pulse for the final frame when the select rises after a whole number of
// frames. Assumes edge strobes come from spi_edge_sync.
module spi_frame_engine
    import spi_chain_pkg::*;
#(
    parameter int MAX_CHAIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] look_addr,
    output logic              miso,
    output logic              miso_oe,
    output logic              thru,
    output logic              commit,
    output logic              commit_wide,
    output logic              commit_rd,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [WORD_W-1:0] commit_data,
    output logic [WORD_W-1:0] commit_snap,
    output logic [POS_W-1:0]  frame_pos
);
    localparam int CNT_W = $clog2(MAX_CHAIN + 2);
    localparam logic [CNT_W-1:0] CHAIN_LIM = CNT_W'(MAX_CHAIN);

    logic              wide_q;
    logic [POS_W-1:0]  pos, pos_nxt, frame_len;
    logic [CNT_W-1:0]  frames;
    logic [WORD_W-2:0] rx_sh;
    logic [FRAME_MAX-1:0] dly;
    logic [CMD_W-1:0]  cmd_byte;
    logic              cmd_rd;
    logic [ADDR_W-1:0] cmd_addr;
    logic [WORD_W-1:0] snap, tx_sh, rd_view;
    logic              rd_act;

    assign frame_len = wide_q ? POS_WIDE : POS_NARROW;
    assign pos_nxt   = pos + 1'b1;
    assign cmd_byte  = {rx_sh[CMD_W-2:0], mosi};
    assign look_addr = cmd_byte[ADDR_W-1:0];
    assign rd_view   = wide_q ? rd_word : {rd_word[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
    assign frame_pos = pos;

    // Receive path: frame position, frame count, command and frame capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0; pos <= '0; frames <= '0; rx_sh <= '0;
            cmd_rd <= 1'b0; cmd_addr <= '0; snap <= '0;
            commit_wide <= 1'b0; commit_rd <= 1'b0; commit_addr <= '0;
            commit_data <= '0; commit_snap <= '0;
        end else if (cs_fall) begin
            pos <= '0; frames <= '0; wide_q <= wide_mode;
        end else if (cs_low && sclk_rise) begin
            rx_sh <= {rx_sh[WORD_W-3:0], mosi};
            if (pos_nxt == POS_CMD) begin
                cmd_rd   <= cmd_byte[CMD_W-1];
                cmd_addr <= look_addr;
                snap     <= cmd_byte[CMD_W-1] ? rd_view : '0;
            end
            if (pos_nxt == frame_len) begin
                pos <= '0;
                if (frames <= CHAIN_LIM) frames <= frames + 1'b1;
                commit_rd   <= cmd_rd;
                commit_addr <= cmd_addr;
                commit_wide <= wide_q;
                commit_snap <= snap;
                commit_data <= wide_q ? {rx_sh, mosi}
                                      : {{BYTE_W{1'b0}}, rx_sh[BYTE_W-2:0], mosi};
            end else begin
                pos <= pos_nxt;
            end
        end
    end

    // Transmit path: read data shifter, output enable and pass-through delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly <= '0; thru <= 1'b0; miso <= 1'b0; miso_oe <= 1'b0;
            rd_act <= 1'b0; tx_sh <= '0;
        end else if (cs_fall) begin
            dly <= '0; thru <= 1'b0; miso_oe <= 1'b0; rd_act <= 1'b0;
        end else if (!cs_low) begin
            miso_oe <= 1'b0; rd_act <= 1'b0;
        end else begin
            if (sclk_rise) begin
                dly <= {dly[FRAME_MAX-2:0], mosi};
                if (pos_nxt == POS_CMD) begin
                    rd_act <= cmd_byte[CMD_W-1];
                    tx_sh  <= rd_view;
                end else if (pos_nxt == frame_len) begin
                    rd_act <= 1'b0;
                end
            end
            if (sclk_fall) begin
                thru <= wide_q ? dly[FRAME_MAX-1] : dly[CMD_W+BYTE_W-1];
                if (rd_act) begin
                    miso    <= tx_sh[WORD_W-1];
                    tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
                    miso_oe <= 1'b1;
                end else begin
                    miso_oe <= 1'b0;
                end
            end
        end
    end

    // Commit pulse: select rose on a frame boundary within the chain limit.
    always_ff @(posedge clk) begin
        if (!rst_n) commit <= 1'b0;
        else        commit <= cs_rise && (pos == '0) && (frames != '0) && (frames <= CHAIN_LIM);
    end
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank: read/write control registers, one sticky status register
// (highest address) with clear-on-read of the returned bits, and the
// interrupt request. Assumes commit fields stay valid while commit is high.
module spi_reg_bank
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int STAT_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            look_addr,
    output logic [WORD_W-1:0]            rd_word,
    input  logic                         commit,
    input  logic                         commit_wide,
    input  logic                         commit_rd,
    input  logic [ADDR_W-1:0]            commit_addr,
    input  logic [WORD_W-1:0]            commit_data,
    input  logic [WORD_W-1:0]            commit_snap,
    input  logic [STAT_W-1:0]            event_in,
    output logic [(NUM_REGS-1)*BYTE_W-1:0] ctrl_flat,
    output logic [STAT_W-1:0]            status,
    output logic [STAT_W-1:0]            clr_mask,
    output logic                         irq_pulldown
);
    localparam int NUM_CTRL = NUM_REGS - 1;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [BYTE_W-1:0] ctrl [NUM_CTRL];
    logic [BYTE_W-1:0] stat_ext, rd_hi, rd_lo;
    logic [ADDR_W-1:0] look_p1, addr_p1;

    assign look_p1 = look_addr + 1'b1;
    assign addr_p1 = commit_addr + 1'b1;

    // Zero-extend the status bits to a byte for reading.
    always_comb begin
        stat_ext = '0;
        stat_ext[STAT_W-1:0] = status;
    end

    // Read mux for the addressed register and its upper neighbour.
    always_comb begin
        rd_hi = '0;
        rd_lo = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (look_addr == ADDR_W'(i)) rd_hi = ctrl[i];
            if (look_p1   == ADDR_W'(i)) rd_lo = ctrl[i];
        end
        if (look_addr == STAT_ADDR) rd_hi = stat_ext;
        if (look_p1   == STAT_ADDR) rd_lo = stat_ext;
    end
    assign rd_word = {rd_hi, rd_lo};

    for (genvar g = 0; g < NUM_CTRL; g++) begin : gen_ctrl
        logic [BYTE_W-1:0] r_q;

        // Control register g: written by a committed write frame.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (commit && !commit_rd) begin
                if (commit_addr == ADDR_W'(g))
                    r_q <= commit_wide ? commit_data[WORD_W-1:BYTE_W] : commit_data[BYTE_W-1:0];
                else if (commit_wide && addr_p1 == ADDR_W'(g))
                    r_q <= commit_data[BYTE_W-1:0];
            end
        end

        assign ctrl[g] = r_q;
        assign ctrl_flat[g*BYTE_W +: BYTE_W] = r_q;
    end

    // Clear mask: the status bits returned by a final-frame status read.
    always_comb begin
        clr_mask = '0;
        if (commit && commit_rd) begin
            if (commit_addr == STAT_ADDR)
                clr_mask = clr_mask | commit_snap[BYTE_W +: STAT_W];
            if (commit_wide && addr_p1 == STAT_ADDR)
                clr_mask = clr_mask | commit_snap[STAT_W-1:0];
        end
    end

    // Sticky status bits and the registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status       <= '0;
            irq_pulldown <= 1'b0;
        end else begin
            status       <= (status & ~clr_mask) | event_in;
            irq_pulldown <= |status;
        end
    end
endmodule

// File: rtl/spi_chain_regif.sv
// Top of the chainable serial register port: input synchroniser, frame
// engine and register bank. Assumes the serial clock is at least five
// times slower than clk and that wide_mode is static while selected.
module spi_chain_regif
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int STAT_W    = 8,
    parameter int MAX_CHAIN = 16,
    parameter int SYNC_STG  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           spi_cs_n,
    input  logic                           spi_sclk,
    input  logic                           spi_mosi,
    input  logic                           wide_mode,
    input  logic [STAT_W-1:0]              event_in,
    output logic                           spi_miso,
    output logic                           spi_miso_oe,
    output logic                           spi_thru,
    output logic                           irq_pulldown,
    output logic [(NUM_REGS-1)*BYTE_W-1:0] ctrl_regs
);
    logic [2:0]        s_level, s_rise, s_fall;
    logic              cs_low, cs_fall, cs_rise;
    logic [ADDR_W-1:0] look_addr, commit_addr;
    logic [WORD_W-1:0] rd_word, commit_data, commit_snap;
    logic              commit, commit_wide, commit_rd;
    logic [POS_W-1:0]  frame_pos;
    logic [STAT_W-1:0] status, clr_mask;

    spi_edge_sync #(.N(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sclk, spi_mosi}),
        .level(s_level), .rise(s_rise), .fall(s_fall)
    );

    assign cs_low  = ~s_level[2];
    assign cs_fall = s_fall[2];
    assign cs_rise = s_rise[2];

    spi_frame_engine #(.MAX_CHAIN(MAX_CHAIN)) u_engine (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_rise(s_rise[1]), .sclk_fall(s_fall[1]), .mosi(s_level[0]),
        .rd_word(rd_word), .look_addr(look_addr),
        .miso(spi_miso), .miso_oe(spi_miso_oe), .thru(spi_thru),
        .commit(commit), .commit_wide(commit_wide), .commit_rd(commit_rd),
        .commit_addr(commit_addr), .commit_data(commit_data),
        .commit_snap(commit_snap), .frame_pos(frame_pos)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS), .STAT_W(STAT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .look_addr(look_addr), .rd_word(rd_word),
        .commit(commit), .commit_wide(commit_wide), .commit_rd(commit_rd),
        .commit_addr(commit_addr), .commit_data(commit_data),
        .commit_snap(commit_snap), .event_in(event_in),
        .ctrl_flat(ctrl_regs), .status(status), .clr_mask(clr_mask),
        .irq_pulldown(irq_pulldown)
    );
endmodule

// File: rtl/spi_chain_regif_chk.sv
// Property checker for spi_chain_regif, attached with bind below.
module spi_chain_regif_chk
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int STAT_W   = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [STAT_W-1:0]              event_in,
    input logic                           irq_pulldown,
    input logic                           spi_miso_oe,
    input logic                           spi_thru,
    input logic [(NUM_REGS-1)*BYTE_W-1:0] ctrl_regs,
    input logic                           commit,
    input logic [POS_W-1:0]               frame_pos,
    input logic                           sclk_fall,
    input logic                           cs_fall,
    input logic                           cs_low,
    input logic [STAT_W-1:0]              status,
    input logic [STAT_W-1:0]              clr_mask
);
    assert_ctrl_only_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_regs) |-> $past(commit));

    assert_commit_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (frame_pos == '0));

    assert_thru_moves_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_thru) |-> $past(sclk_fall || cs_fall));

    assert_oe_within_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> $past(cs_low));

    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_mask) == '0) |-> ((status & $past(status)) == $past(status)));

    assert_event_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_in) |=> ##1 irq_pulldown);
endmodule

bind spi_chain_regif spi_chain_regif_chk #(.NUM_REGS(NUM_REGS), .STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .irq_pulldown(irq_pulldown),
    .spi_miso_oe(spi_miso_oe), .spi_thru(spi_thru), .ctrl_regs(ctrl_regs),
    .commit(commit), .frame_pos(frame_pos), .sclk_fall(s_fall[1]),
    .cs_fall(cs_fall), .cs_low(cs_low), .status(status), .clr_mask(clr_mask)
);

// File: tb/test_spi_chain_regif.sv
module test_spi_chain_regif;
    localparam int H = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0, wide_mode = 1'b0;
    logic [7:0]   event_in = '0;
    logic         spi_miso, spi_miso_oe, spi_thru, irq_pulldown;
    logic [119:0] ctrl_regs, pre_rise_ctrl;

    always #2 clk = ~clk;

    spi_chain_regif i_spi_chain_regif (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .wide_mode(wide_mode), .event_in(event_in),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .spi_thru(spi_thru),
        .irq_pulldown(irq_pulldown), .ctrl_regs(ctrl_regs)
    );

    typedef struct { int w; logic [15:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    logic bits_q[$];
    logic [7:0] m_ctrl [15];
    logic [7:0] m_stat;
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic logic [7:0] peek(input int a);
        if (a < 15)  return m_ctrl[a];
        if (a == 15) return m_stat;
        return 8'h00;
    endfunction

    function automatic logic [7:0] reg_of(input int i);
        return ctrl_regs[i*8 +: 8];
    endfunction

    function automatic bit ctrl_matches();
        for (int i = 0; i < 15; i++) if (reg_of(i) !== m_ctrl[i]) return 0;
        return 1;
    endfunction

    // Append one frame; a read also queues its expected data for the monitor.
    task automatic push_frame(input bit wide, input bit rd, input int addr,
                              input logic [15:0] data, input string tag);
        logic [7:0] cmd;
        exp_t e;
        cmd = {rd, addr[6:0]};
        for (int b = 7; b >= 0; b--) bits_q.push_back(cmd[b]);
        for (int b = (wide ? 15 : 7); b >= 0; b--) bits_q.push_back(rd ? 1'b0 : data[b]);
        if (rd) begin
            e.w = wide ? 16 : 8;
            e.v = wide ? {peek(addr), peek((addr + 1) % 128)} : {8'h00, peek(addr)};
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // Drive the queued bits in one select window and check the pass-through.
    task automatic run_xfer(input bit wide, input int ev_bit, input logic [7:0] ev_val);
        int f, n, bad;
        logic expb;
        f = wide ? 24 : 16;
        n = bits_q.size();
        bad = 0;
        wide_mode = wide;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            spi_mosi = bits_q[i];
            if (i == ev_bit) event_in = ev_val;
            @(negedge clk);
            event_in = '0;
            repeat (H - 1) @(negedge clk);
            expb = (i >= f) ? bits_q[i - f] : 1'b0;
            if (spi_thru !== expb) bad++;
            spi_sclk = 1'b1;
            repeat (H) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        pre_rise_ctrl = ctrl_regs;
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
        bits_q.delete();
        check(bad == 0, "R6", "pass-through mismatches", bad, 0);
        check(spi_miso_oe == 1'b0, "R7", "output enable after select rise", spi_miso_oe, 0);
    endtask

    // Monitor: collect driven read bits and compare with the scoreboard.
    initial begin
        logic [15:0] sh;
        int cnt;
        exp_t e;
        sh = '0;
        cnt = 0;
        forever begin
            @(posedge spi_sclk);
            if (spi_miso_oe) begin
                sh = {sh[14:0], spi_miso};
                cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R7", "read data with nothing expected", sh, 0);
                    cnt = 0;
                end else if (cnt == exp_q[0].w) begin
                    e = exp_q.pop_front();
                    if (e.w == 8) check(sh[7:0] === e.v[7:0], e.tag, "read byte", sh[7:0], e.v[7:0]);
                    else          check(sh === e.v, e.tag, "read word", sh, e.v);
                    cnt = 0;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=%h expected=%h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 15; i++) m_ctrl[i] = 8'h00;
        m_stat = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check(spi_miso_oe == 1'b0, "R1", "oe after reset", spi_miso_oe, 0);
        check(spi_thru == 1'b0, "R1", "thru after reset", spi_thru, 0);
        check(irq_pulldown == 1'b0, "R1", "irq after reset", irq_pulldown, 0);
        check(ctrl_regs == '0, "R1", "ctrl after reset", ctrl_regs[31:0], 0);

        // R2 narrow write, committed only at select rise
        push_frame(0, 0, 3, 16'h00A5, "R2");
        run_xfer(0, -1, 8'h00);
        check(pre_rise_ctrl == '0, "R2", "no write before select rise", pre_rise_ctrl[31:0], 0);
        check(reg_of(3) == 8'hA5, "R2", "reg3 after write", reg_of(3), 8'hA5);
        m_ctrl[3] = 8'hA5;

        // R7 narrow read
        push_frame(0, 1, 3, 16'h0, "R7");
        run_xfer(0, -1, 8'h00);

        // R3 wide write and read
        push_frame(1, 0, 6, 16'h1234, "R3");
        run_xfer(1, -1, 8'h00);
        check(reg_of(6) == 8'h12, "R3", "reg6 first byte", reg_of(6), 8'h12);
        check(reg_of(7) == 8'h34, "R3", "reg7 second byte", reg_of(7), 8'h34);
        m_ctrl[6] = 8'h12; m_ctrl[7] = 8'h34;
        push_frame(1, 1, 6, 16'h0, "R3");
        run_xfer(1, -1, 8'h00);

        // R4 one bit short, then four bits over
        push_frame(0, 0, 2, 16'h003C, "R4");
        void'(bits_q.pop_back());
        run_xfer(0, -1, 8'h00);
        check(reg_of(2) == 8'h00, "R4", "short frame ignored", reg_of(2), 0);
        push_frame(0, 0, 2, 16'h003C, "R4");
        for (int i = 0; i < 4; i++) bits_q.push_back(1'b1);
        run_xfer(0, -1, 8'h00);
        check(reg_of(2) == 8'h00, "R4", "long frame ignored", reg_of(2), 0);

        // R5 chain of three frames: only the last commits
        push_frame(0, 0, 1, 16'h0011, "R5");
        push_frame(0, 0, 1, 16'h0022, "R5");
        push_frame(0, 0, 4, 16'h0077, "R5");
        run_xfer(0, -1, 8'h00);
        check(reg_of(1) == 8'h00, "R5", "non-final frame ignored", reg_of(1), 0);
        check(reg_of(4) == 8'h77, "R5", "final frame committed", reg_of(4), 8'h77);
        m_ctrl[4] = 8'h77;
        push_frame(0, 1, 3, 16'h0, "R5");
        push_frame(0, 1, 4, 16'h0, "R5");
        run_xfer(0, -1, 8'h00);

        // R11 seventeen frames discarded, sixteen committed
        for (int k = 0; k < 17; k++) push_frame(0, 0, 5, 16'h0099, "R11");
        run_xfer(0, -1, 8'h00);
        check(reg_of(5) == 8'h00, "R11", "17 frames discarded", reg_of(5), 0);
        for (int k = 0; k < 16; k++) push_frame(0, 0, 5, 16'h0099, "R11");
        run_xfer(0, -1, 8'h00);
        check(reg_of(5) == 8'h99, "R11", "16 frames committed", reg_of(5), 8'h99);
        m_ctrl[5] = 8'h99;

        // R8 writes to status and unimplemented addresses change nothing
        push_frame(0, 0, 40, 16'h00FF, "R8");
        run_xfer(0, -1, 8'h00);
        push_frame(0, 0, 15, 16'h00FF, "R8");
        run_xfer(0, -1, 8'h00);
        push_frame(1, 0, 14, 16'hABCD, "R8");
        run_xfer(1, -1, 8'h00);
        m_ctrl[14] = 8'hAB;
        check(ctrl_matches(), "R8", "ctrl after ignored writes", reg_of(14), 8'hAB);
        check(irq_pulldown == 1'b0, "R8", "status untouched by write", irq_pulldown, 0);
        push_frame(0, 1, 40, 16'h0, "R8");
        run_xfer(0, -1, 8'h00);

        // R9 event sets sticky status and interrupt
        @(negedge clk); event_in = 8'h05;
        @(negedge clk); event_in = 8'h00;
        repeat (4) @(negedge clk);
        check(irq_pulldown == 1'b1, "R9", "irq after event", irq_pulldown, 1);
        m_stat = 8'h05;

        // R10 final-frame status read clears
        push_frame(0, 1, 15, 16'h0, "R10");
        run_xfer(0, -1, 8'h00);
        m_stat = 8'h00;
        check(irq_pulldown == 1'b0, "R10", "irq after status read", irq_pulldown, 0);

        // R10 non-final status read keeps bits
        @(negedge clk); event_in = 8'h08;
        @(negedge clk); event_in = 8'h00;
        repeat (4) @(negedge clk);
        m_stat = 8'h08;
        push_frame(0, 1, 15, 16'h0, "R10");
        push_frame(0, 0, 0, 16'h005A, "R10");
        run_xfer(0, -1, 8'h00);
        m_ctrl[0] = 8'h5A;
        check(irq_pulldown == 1'b1, "R10", "irq kept after non-final read", irq_pulldown, 1);
        check(reg_of(0) == 8'h5A, "R5", "final write after read", reg_of(0), 8'h5A);

        // R10 event during the data phase survives the clear
        push_frame(0, 1, 15, 16'h0, "R10");
        run_xfer(0, 11, 8'h02);
        m_stat = 8'h02;
        check(irq_pulldown == 1'b1, "R10", "late event kept", irq_pulldown, 1);
        push_frame(0, 1, 15, 16'h0, "R10");
        run_xfer(0, -1, 8'h00);
        m_stat = 8'h00;
        check(irq_pulldown == 1'b0, "R10", "irq after second read", irq_pulldown, 0);

        check(exp_q.size() == 0, "R7", "unanswered reads", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule